// File: doc/BRIEF.md
# Reconfigurable Spiking Neuron Core

This block advances the state of a single spiking neuron by one time step each time its step strobe is accepted. A 2-bit mode picks one of three neuron models: a plain integrator, a leaky integrator, or a two-state model in which a separate synaptic current decays and feeds the membrane. All additions, subtractions and threshold comparisons use exact signed fixed-point arithmetic with saturation, so rounding never builds up from step to step.

The decay products (current times alpha, membrane times beta) are not computed here. They are requested from an external multiplier, which may be an approximate bit-stream unit, over a request/acknowledge pair. The core presents an operand and an unsigned factor and waits for a product. It accepts a new step only while idle, and reports a spike bit together with its membrane and synaptic state.

Top module: `spk_neuron_core`

## Requirements
- R1: After reset the membrane, synaptic current and spike output are zero, and both the multiply request and busy are low.
- R2: With mode code 0 or 3 (integrate), an accepted step sets the pre-fire membrane to the saturated sum of membrane and input in the same clock edge, with no multiply request.
- R3: With mode code 1 (leaky), an accepted step raises one multiply request with operand = membrane and factor = beta; on acknowledge the pre-fire membrane is the saturated sum of the returned product and the input.
- R4: With mode code 2 (synaptic), the first request carries operand = synaptic current and factor = alpha, and on acknowledge the current becomes the saturated sum of product and input; the second request carries operand = membrane and factor = beta, and on acknowledge the pre-fire membrane is the saturated sum of product and the new current.
- R5: When the pre-fire membrane is greater than or equal to the threshold, spike_o is 1 and the membrane becomes the pre-fire value minus the threshold; otherwise spike_o is 0 and the membrane takes the pre-fire value. spike_o holds until the next step completes.
- R6: Every sum and difference clamps to the signed limits of STATE_W (32767 and -32768 by default) instead of wrapping.
- R7: A multiply request, its operand and its factor stay unchanged until acknowledged; an acknowledge while no request is raised changes nothing.
- R8: A step strobe while busy is ignored; the mode, input, threshold and factors are sampled at the accepted strobe, so later changes do not affect that step.
- R9: The synaptic current changes only in mode code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Time-step strobe, accepted while idle |
| mode_i | input | 2 | Neuron model: 0 integrate, 1 leaky, 2 synaptic, 3 integrate |
| in_sum_i | input | STATE_W | Signed weighted input sum for this step |
| thresh_i | input | STATE_W | Signed firing threshold |
| beta_i | input | FACT_W | Membrane decay factor (unsigned fraction) |
| alpha_i | input | FACT_W | Synaptic decay factor (unsigned fraction) |
| mul_req_o | output | 1 | Multiply request |
| mul_opnd_o | output | STATE_W | Signed operand to be scaled |
| mul_fact_o | output | FACT_W | Factor for the requested product |
| mul_ack_i | input | 1 | Product valid, completes the request |
| mul_prod_i | input | STATE_W | Signed product from the multiplier |
| busy_o | output | 1 | A step is in progress |
| spike_o | output | 1 | Spike result of the last completed step |
| mem_o | output | STATE_W | Membrane state |
| syn_o | output | STATE_W | Synaptic current state |

## Verification
Integrate mode is driven with small inputs through both of its codes and then pushed across the threshold, which separates plain accumulation from the subtract-on-fire reset. Leaky and synaptic steps are served by a bench multiplier whose products differ from the raw operands, so the order of requests, the operand and factor of each, and the use of the new current rather than the old one in the membrane sum all show in the final state. Large same-sign inputs expose wrap versus clamp at both limits, and a deliberately late acknowledge with a stray strobe and changed inputs during the wait, plus an acknowledge with no request pending, show that only the sampled step is applied.

// File: rtl/spk_pkg.sv
package spk_pkg;

    typedef enum logic [1:0] {
        MODE_IF     = 2'd0,
        MODE_LIF    = 2'd1,
        MODE_SYN    = 2'd2,
        MODE_IF_ALT = 2'd3
    } nmode_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SYN_MUL = 2'd1,
        PH_MEM_MUL = 2'd2
    } phase_e;

endpackage

// File: rtl/spk_sat_add.sv
module spk_sat_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o
);
    localparam logic signed [W:0] MAX_V = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [W:0] MIN_V = {2'b11, {(W-1){1'b0}}};

    logic signed [W:0] wide;

    always_comb begin
        if (sub_i) begin
            wide = {a_i[W-1], a_i} - {b_i[W-1], b_i};
        end else begin
            wide = {a_i[W-1], a_i} + {b_i[W-1], b_i};
        end
        if (wide > MAX_V) begin
            y_o = MAX_V[W-1:0];
        end else if (wide < MIN_V) begin
            y_o = MIN_V[W-1:0];
        end else begin
            y_o = wide[W-1:0];
        end
    end
endmodule

// File: rtl/spk_fire_unit.sv
module spk_fire_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] pre_i,
    input  logic [W-1:0] thr_i,
    output logic         hit_o,
    output logic [W-1:0] post_o
);
    logic [W-1:0] reduced;

    spk_sat_add #(.W(W)) u_sub (
        .a_i   (pre_i),
        .b_i   (thr_i),
        .sub_i (1'b1),
        .y_o   (reduced)
    );

    always_comb begin
        hit_o  = $signed(pre_i) >= $signed(thr_i);
        post_o = hit_o ? reduced : pre_i;
    end
endmodule

// File: rtl/spk_neuron_core.sv
module spk_neuron_core
    import spk_pkg::*;
#(
    parameter int STATE_W = 16,
    parameter int FACT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    input  logic [1:0]         mode_i,
    input  logic [STATE_W-1:0] in_sum_i,
    input  logic [STATE_W-1:0] thresh_i,
    input  logic [FACT_W-1:0]  beta_i,
    input  logic [FACT_W-1:0]  alpha_i,
    output logic               mul_req_o,
    output logic [STATE_W-1:0] mul_opnd_o,
    output logic [FACT_W-1:0]  mul_fact_o,
    input  logic               mul_ack_i,
    input  logic [STATE_W-1:0] mul_prod_i,
    output logic               busy_o,
    output logic               spike_o,
    output logic [STATE_W-1:0] mem_o,
    output logic [STATE_W-1:0] syn_o
);
    typedef struct packed {
        phase_e             phase;
        logic [1:0]         mode;
        logic [STATE_W-1:0] in_sum;
        logic [STATE_W-1:0] thr;
        logic [FACT_W-1:0]  beta;
        logic [FACT_W-1:0]  alpha;
        logic [STATE_W-1:0] mem;
        logic [STATE_W-1:0] syn;
        logic               spike;
    } core_t;

    core_t state_d, state_q;

    logic [STATE_W-1:0] add_a, add_b, add_sum;
    logic [STATE_W-1:0] fire_thr, fire_post;
    logic               fire_hit;

    // operand selection for the single exact accumulator
    always_comb begin
        add_a    = mul_prod_i;
        add_b    = state_q.in_sum;
        fire_thr = state_q.thr;
        unique case (state_q.phase)
            PH_IDLE: begin
                add_a    = state_q.mem;
                add_b    = in_sum_i;
                fire_thr = thresh_i;
            end
            PH_SYN_MUL: begin
                add_b = state_q.in_sum;
            end
            PH_MEM_MUL: begin
                add_b = (state_q.mode == MODE_SYN) ? state_q.syn : state_q.in_sum;
            end
            default: begin
                add_b = state_q.in_sum;
            end
        endcase
    end

    spk_sat_add #(.W(STATE_W)) u_acc (
        .a_i   (add_a),
        .b_i   (add_b),
        .sub_i (1'b0),
        .y_o   (add_sum)
    );

    spk_fire_unit #(.W(STATE_W)) u_fire (
        .pre_i  (add_sum),
        .thr_i  (fire_thr),
        .hit_o  (fire_hit),
        .post_o (fire_post)
    );

    // next-state computation
    always_comb begin
        state_d = state_q;
        unique case (state_q.phase)
            PH_IDLE: begin
                if (step_i) begin
                    state_d.mode   = mode_i;
                    state_d.in_sum = in_sum_i;
                    state_d.thr    = thresh_i;
                    state_d.beta   = beta_i;
                    state_d.alpha  = alpha_i;
                    if (mode_i == MODE_LIF) begin
                        state_d.phase = PH_MEM_MUL;
                    end else if (mode_i == MODE_SYN) begin
                        state_d.phase = PH_SYN_MUL;
                    end else begin
                        state_d.mem   = fire_post;
                        state_d.spike = fire_hit;
                    end
                end
            end
            PH_SYN_MUL: begin
                if (mul_ack_i) begin
                    state_d.syn   = add_sum;
                    state_d.phase = PH_MEM_MUL;
                end
            end
            PH_MEM_MUL: begin
                if (mul_ack_i) begin
                    state_d.mem   = fire_post;
                    state_d.spike = fire_hit;
                    state_d.phase = PH_IDLE;
                end
            end
            default: begin
                state_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        busy_o     = state_q.phase != PH_IDLE;
        mul_req_o  = busy_o;
        mul_opnd_o = (state_q.phase == PH_SYN_MUL) ? state_q.syn : state_q.mem;
        mul_fact_o = (state_q.phase == PH_SYN_MUL) ? state_q.alpha : state_q.beta;
        spike_o    = state_q.spike;
        mem_o      = state_q.mem;
        syn_o      = state_q.syn;
    end
endmodule

// File: rtl/spk_neuron_core_chk.sv
module spk_neuron_core_chk #(
    parameter int STATE_W = 16,
    parameter int FACT_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               step_i,
    input logic [1:0]         mode_i,
    input logic [FACT_W-1:0]  beta_i,
    input logic [FACT_W-1:0]  alpha_i,
    input logic               mul_req_o,
    input logic [STATE_W-1:0] mul_opnd_o,
    input logic [FACT_W-1:0]  mul_fact_o,
    input logic               mul_ack_i,
    input logic               busy_o,
    input logic               spike_o,
    input logic [STATE_W-1:0] mem_o,
    input logic [STATE_W-1:0] syn_o
);
    a_r2_if_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !busy_o && (mode_i == 2'd0 || mode_i == 2'd3)) |=> !mul_req_o);

    a_r3_lif_request: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !busy_o && mode_i == 2'd1) |=>
        (mul_req_o && mul_fact_o == $past(beta_i) && mul_opnd_o == $past(mem_o)));

    a_r4_syn_first_request: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !busy_o && mode_i == 2'd2) |=>
        (mul_req_o && mul_fact_o == $past(alpha_i) && mul_opnd_o == $past(syn_o)));

    a_r7_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_req_o && !mul_ack_i) |=>
        (mul_req_o && $stable(mul_opnd_o) && $stable(mul_fact_o)));

    a_r7_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !step_i) |=> ($stable(mem_o) && $stable(syn_o) && $stable(spike_o)));

    a_r9_syn_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !busy_o && mode_i != 2'd2) |=> $stable(syn_o));
endmodule

bind spk_neuron_core spk_neuron_core_chk #(.STATE_W(STATE_W), .FACT_W(FACT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .mode_i     (mode_i),
    .beta_i     (beta_i),
    .alpha_i    (alpha_i),
    .mul_req_o  (mul_req_o),
    .mul_opnd_o (mul_opnd_o),
    .mul_fact_o (mul_fact_o),
    .mul_ack_i  (mul_ack_i),
    .busy_o     (busy_o),
    .spike_o    (spike_o),
    .mem_o      (mem_o),
    .syn_o      (syn_o)
);

// File: tb/spk_neuron_core_test.sv
module spk_neuron_core_test;
    localparam int SW = 16;
    localparam int FW = 8;
    localparam int VMAX = 32767;
    localparam int VMIN = -32768;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 step = 1'b0;
    logic [1:0]           mode = 2'd0;
    logic signed [SW-1:0] in_sum = '0;
    logic signed [SW-1:0] thresh = '0;
    logic [FW-1:0]        beta = '0;
    logic [FW-1:0]        alpha = '0;
    logic                 req;
    logic signed [SW-1:0] opnd;
    logic [FW-1:0]        fact;
    logic                 ack = 1'b0;
    logic signed [SW-1:0] prod = '0;
    logic                 busy;
    logic                 spike;
    logic signed [SW-1:0] mem;
    logic signed [SW-1:0] syn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_mem, m_syn, m_spk;
    int rec_n;
    int rec_op[4];
    int rec_fa[4];

    always #2 clk = ~clk;

    spk_neuron_core #(.STATE_W(SW), .FACT_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .step_i(step), .mode_i(mode),
        .in_sum_i(in_sum), .thresh_i(thresh), .beta_i(beta), .alpha_i(alpha),
        .mul_req_o(req), .mul_opnd_o(opnd), .mul_fact_o(fact),
        .mul_ack_i(ack), .mul_prod_i(prod), .busy_o(busy),
        .spike_o(spike), .mem_o(mem), .syn_o(syn)
    );

    function automatic int clampv(int v);
        if (v > VMAX) return VMAX;
        if (v < VMIN) return VMIN;
        return v;
    endfunction

    function automatic int scale(int o, int f);
        return (o * f) >>> FW;
    endfunction

    task automatic check_val(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        step = 1'b0;
        ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_mem = 0; m_syn = 0; m_spk = 0;
    endtask

    // model of one step, written from the requirements
    task automatic model_step(int md, int x, int th, int b, int a, output int nreq);
        int pre;
        if (md == 1) begin
            pre = clampv(scale(m_mem, b) + x);
            nreq = 1;
        end else if (md == 2) begin
            m_syn = clampv(scale(m_syn, a) + x);
            pre = clampv(scale(m_mem, b) + m_syn);
            nreq = 2;
        end else begin
            pre = clampv(m_mem + x);
            nreq = 0;
        end
        if (pre >= th) begin
            m_spk = 1;
            m_mem = clampv(pre - th);
        end else begin
            m_spk = 0;
            m_mem = pre;
        end
    endtask

    task automatic serve_mult();
        int guard = 0;
        rec_n = 0;
        while (busy && guard < 20) begin
            ack = req;
            prod = SW'(scale(int'(opnd), int'(fact)));
            if (req && rec_n < 4) begin
                rec_op[rec_n] = int'(opnd);
                rec_fa[rec_n] = int'(fact);
                rec_n++;
            end
            guard++;
            @(negedge clk);
        end
        ack = 1'b0;
    endtask

    task automatic do_step(string tag, int md, int x, int th, int b, int a);
        int nreq;
        int old_mem = m_mem;
        int old_syn = m_syn;
        mode = 2'(md); in_sum = SW'(x); thresh = SW'(th); beta = FW'(b); alpha = FW'(a);
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        serve_mult();
        model_step(md, x, th, b, a, nreq);
        check_val({tag, " request count"}, rec_n, nreq);
        if (nreq == 1) begin
            check_val({tag, " R3 operand"}, rec_op[0], old_mem);
            check_val({tag, " R3 factor"}, rec_fa[0], b);
        end
        if (nreq == 2) begin
            check_val({tag, " R4 first operand"}, rec_op[0], old_syn);
            check_val({tag, " R4 first factor"}, rec_fa[0], a);
            check_val({tag, " R4 second operand"}, rec_op[1], old_mem);
            check_val({tag, " R4 second factor"}, rec_fa[1], b);
        end
        check_val({tag, " membrane"}, int'(mem), m_mem);
        check_val({tag, " R5 spike"}, int'(spike), m_spk);
        check_val({tag, " R9 synaptic"}, int'(syn), m_syn);
    endtask

    task automatic t_reset();
        apply_reset();
        check_val("R1 membrane", int'(mem), 0);
        check_val("R1 synaptic", int'(syn), 0);
        check_val("R1 spike", int'(spike), 0);
        check_val("R1 request", int'(req), 0);
        check_val("R1 busy", int'(busy), 0);
    endtask

    task automatic t_integrate();
        apply_reset();
        do_step("R2 code0", 0, 100, 1000, 128, 128);
        do_step("R2 code3", 3, 50, 1000, 128, 128);
        do_step("R5 fire", 0, 900, 1000, 128, 128);
        do_step("R5 below", 0, -20, 1000, 128, 128);
        check_val("R5 spike cleared", int'(spike), 0);
    endtask

    task automatic t_leaky();
        apply_reset();
        do_step("R3 load", 0, 800, 2000, 0, 0);
        do_step("R3 decay", 1, 40, 2000, 192, 0);
        do_step("R3 decay neg input", 1, -300, 2000, 128, 0);
        do_step("R3 fire", 1, 1900, 1500, 230, 0);
    endtask

    task automatic t_synaptic();
        apply_reset();
        do_step("R4 first", 2, 600, 5000, 200, 128);
        do_step("R4 second", 2, 300, 5000, 200, 64);
        do_step("R4 fire", 2, 4000, 1200, 250, 250);
        do_step("R9 leaky keeps syn", 1, 10, 5000, 100, 0);
        do_step("R9 integrate keeps syn", 0, 10, 5000, 0, 0);
    endtask

    task automatic t_saturate();
        apply_reset();
        do_step("R6 high a", 0, 30000, 32767, 0, 0);
        do_step("R6 high clamp", 0, 30000, 32767, 0, 0);
        check_val("R6 high spike", int'(spike), 1);
        apply_reset();
        do_step("R6 low a", 0, -30000, 1000, 0, 0);
        do_step("R6 low clamp", 0, -30000, 1000, 0, 0);
        check_val("R6 low value", int'(mem), VMIN);
    endtask

    task automatic t_handshake();
        int held_op;
        int held_fa;
        int nreq;
        apply_reset();
        do_step("R8 load", 0, 400, 10000, 0, 0);
        mode = 2'd1; in_sum = 16'sd10; thresh = 16'sd10000; beta = 8'd128; alpha = 8'd0;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        held_op = int'(opnd);
        held_fa = int'(fact);
        mode = 2'd0; in_sum = 16'sd5000; thresh = 16'sd1; beta = 8'd3;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        repeat (2) @(negedge clk);
        check_val("R7 request held", int'(req), 1);
        check_val("R7 operand held", int'(opnd), held_op);
        check_val("R8 factor held", int'(fact), held_fa);
        check_val("R8 membrane untouched while busy", int'(mem), m_mem);
        serve_mult();
        model_step(1, 10, 10000, 128, 0, nreq);
        check_val("R8 sampled step result", int'(mem), m_mem);
        check_val("R8 busy cleared", int'(busy), 0);
        repeat (2) @(negedge clk);
        check_val("R8 no extra step", int'(mem), m_mem);
        ack = 1'b1;
        prod = 16'sd12345;
        repeat (2) @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        check_val("R7 stray ack membrane", int'(mem), m_mem);
        check_val("R7 stray ack spike", int'(spike), m_spk);
        check_val("R7 stray ack request", int'(req), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_integrate();
        t_leaky();
        t_synaptic();
        t_saturate();
        t_handshake();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule